// File: doc/BRIEF.md
# Iterative Circular Rotation Engine (CORDIC)

The block turns a vector through an angle by running one shift-and-add micro-rotation per clock. Software or a neighbouring datapath drives an angle, an optional vector and a two-bit mode, then pulses `start`. The engine loads its three working registers, runs a fixed number of micro-rotations and raises `done` for one cycle. At that point `x_out` and `y_out` hold the result.

The mode picks only how the registers are preloaded, and the same datapath serves three uses:

- **Sine and cosine.** X starts at the reciprocal of the rotation gain and Y at zero, so the results are cos θ and sin θ directly, with no gain correction.
- **Vector rotation.** The raw input vector is loaded, and the result is that vector rotated by θ and scaled by the gain of about 1.6468.
- **Polar to rectangular.** The magnitude is multiplied by the reciprocal gain once at load time, so the results are m·cos θ and m·sin θ.

Before iterating, a coarse step folds angles beyond a quarter turn back by half a turn and negates the preloaded vector. This gives the engine the full ±π range.

Number formats:

- Angles are signed `W`-bit values in which 2^(W-1) stands for π.
- X and Y are signed values with `W-2` fractional bits.
- In vector-rotate mode the input magnitude must stay below about 1.2 so that the gain-scaled result fits.

Top module: `cordic_rotator`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `x_out` and `y_out` are 0.
- R2: With mode 00, `x_out` equals cos θ and `y_out` equals sin θ within 4096 LSB of the Q2.30 value. θ is `z_in`·π/2^31.
- R3: A `start` sampled while idle makes `done` high for exactly one cycle, on the ITER+1-th rising edge counted from the edge that sampled `start` (31 for ITER=30). `busy` is high from the edge after the sampling edge until that edge.
- R4: Angles between ±π/2 and ±π, including the codes 0x7FFFFFFF and 0x80000000, give the correct result in every mode through the coarse half-turn fold.
- R5: With mode 01, the result is 1.6467602581·(x·cos θ − y·sin θ, x·sin θ + y·cos θ) within 4096 LSB.
- R6: With mode 10, `x_in` is a magnitude m, and the result is (m·cos θ, m·sin θ) within 4096 LSB.
- R7: A `start` pulse while `busy` is high is ignored. The running result, the `done` timing and the absence of a second `done` are unchanged.
- R8: Once `done` has pulsed, `x_out` and `y_out` stay constant while no `start` arrives, whatever the data inputs do.
- R9: Mode 11 behaves exactly like mode 01.
- R10: While iterating, the internal angle residue stays strictly within ±3·2^29.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a computation when idle |
| mode | input | 2 | 00 sin/cos, 01 rotate, 10 polar, 11 rotate |
| x_in | input | W | Vector X or polar magnitude, Q2.30 |
| y_in | input | W | Vector Y, Q2.30 |
| z_in | input | W | Angle, 2^(W-1) = π |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle completion pulse |
| x_out | output | W | Result X, Q2.30 |
| y_out | output | W | Result Y, Q2.30 |

## Verification
A wrong micro-rotation direction, a wrong table entry or a bad fold does not stop the engine. Instead it moves the final vector, and this is visible only at the `done` pulse, 31 cycles after `start`. The angle tests therefore include one in each quadrant and both extreme codes. A miscounted iteration index shows at once as `done` arriving on the wrong edge. A start that should have been ignored shows as changed results or a second `done` pulse within the following cycles.

// File: rtl/cordic_rotator.sv
module cordic_rotator #(
  parameter int W    = 32,
  parameter int ITER = 30,
  localparam int IW  = $clog2(ITER)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [1:0]          mode,
  input  logic signed [W-1:0] x_in,
  input  logic signed [W-1:0] y_in,
  input  logic signed [W-1:0] z_in,
  output logic                busy,
  output logic                done,
  output logic signed [W-1:0] x_out,
  output logic signed [W-1:0] y_out
);

  localparam real PI_R = 3.14159265358979323846;
  localparam logic signed [W-1:0] QUARTER = W'(1) <<< (W-2);
  localparam logic signed [W-1:0] HALF    = W'(1) <<< (W-1);
  localparam logic signed [W-1:0] KINV    = W'($rtoi(0.6072529350088813 * (2.0 ** (W-2)) + 0.5));
  localparam logic signed [W-1:0] ZLIM    = W'(3) <<< (W-3);

  function automatic logic signed [W-1:0] atan_code(input int i);
    real r;
    r = $atan(2.0 ** (-i)) / PI_R * (2.0 ** (W-1));
    return W'($rtoi(r + 0.5));
  endfunction

  function automatic logic signed [W-1:0] gain_comp(input logic signed [W-1:0] v);
    logic signed [2*W-1:0] p;
    p = v * KINV;
    return p[2*W-3:W-2];
  endfunction

  logic signed [W-1:0] atan_tab [ITER];
  for (genvar g = 0; g < ITER; g++) begin : g_tab
    localparam logic signed [W-1:0] ENTRY = atan_code(g);
    assign atan_tab[g] = ENTRY;
  end

  logic signed [W-1:0] x_q, y_q, z_q;
  logic [IW-1:0]       idx_q;
  logic                busy_q, done_q;

  logic signed [W-1:0] x_seed, y_seed, z_fold;
  logic                fold;

  always_comb begin
    case (mode)
      2'b00:   begin x_seed = KINV;            y_seed = '0;   end
      2'b10:   begin x_seed = gain_comp(x_in); y_seed = '0;   end
      default: begin x_seed = x_in;            y_seed = y_in; end
    endcase
  end

  assign fold   = (z_in > QUARTER) || (z_in < -QUARTER);
  assign z_fold = fold ? z_in + HALF : z_in;

  logic signed [W-1:0] x_sh, y_sh, ang;
  assign x_sh = x_q >>> idx_q;
  assign y_sh = y_q >>> idx_q;
  assign ang  = atan_tab[idx_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q    <= '0;
      y_q    <= '0;
      z_q    <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          x_q    <= fold ? -x_seed : x_seed;
          y_q    <= fold ? -y_seed : y_seed;
          z_q    <= z_fold;
          idx_q  <= '0;
          busy_q <= 1'b1;
        end
      end else begin
        if (!z_q[W-1]) begin
          x_q <= x_q - y_sh;
          y_q <= y_q + x_sh;
          z_q <= z_q - ang;
        end else begin
          x_q <= x_q + y_sh;
          y_q <= y_q - x_sh;
          z_q <= z_q + ang;
        end
        if (idx_q == IW'(ITER-1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign busy  = busy_q;
  assign done  = done_q;
  assign x_out = x_q;
  assign y_out = y_q;

  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  assert_done_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(busy_q) && $past(idx_q) == IW'(ITER-1));

  assert_index_steps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && idx_q != IW'(ITER-1) |=> busy_q && idx_q == $past(idx_q) + 1'b1);

  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && start && idx_q != IW'(ITER-1) |=> busy_q && idx_q != '0);

  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q && !start |=> $stable(x_q) && $stable(y_q) && !busy_q);

  assert_residue_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (z_q < ZLIM) && (z_q > -ZLIM));

endmodule

// File: tb/cordic_rotator_test.sv
module cordic_rotator_test;
  localparam int CLK_PERIOD = 10;
  localparam int ITER = 30;
  localparam int TOL = 4096;
  localparam real PI_R = 3.14159265358979323846;
  localparam real GAIN = 1.6467602581;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] mode = 2'b00;
  logic signed [31:0] x_in = '0, y_in = '0, z_in = '0;
  logic busy, done;
  logic signed [31:0] x_out, y_out;

  int checks = 0;
  int failures = 0;
  int cycles_total = 0;
  bit finished = 0;

  cordic_rotator #(.W(32), .ITER(ITER)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .x_in(x_in), .y_in(y_in), .z_in(z_in),
    .busy(busy), .done(done), .x_out(x_out), .y_out(y_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic signed [31:0] ang_code(real deg);
    real r;
    r = deg / 180.0 * 2147483648.0;
    if (r > 2147483647.0) r = 2147483647.0;
    if (r < -2147483648.0) r = -2147483648.0;
    return 32'($rtoi(r));
  endfunction

  function automatic real code_rad(logic signed [31:0] z);
    return $itor(z) / 2147483648.0 * PI_R;
  endfunction

  function automatic logic signed [31:0] q30(real v);
    return 32'($rtoi(v * 1073741824.0));
  endfunction

  task automatic check_eq(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_near(string tag, logic signed [31:0] act, real exp);
    longint e, d;
    checks++;
    e = longint'($rtoi(exp * 1073741824.0));
    d = longint'(act) - e;
    if (d < 0) d = -d;
    if (d > TOL) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, e);
    end
  endtask

  task automatic launch(logic [1:0] m, logic signed [31:0] x, logic signed [31:0] y,
                        logic signed [31:0] z);
    @(negedge clk);
    mode = m; x_in = x; y_in = y; z_in = z; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(string tag);
    int cyc = 1;
    while (!done && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    check_eq({tag, " R3 latency"}, cyc, ITER + 1);
  endtask

  task automatic run_and_check(string tag, logic [1:0] m, real xv, real yv, real deg,
                               real ex, real ey);
    launch(m, q30(xv), q30(yv), ang_code(deg));
    wait_done(tag);
    check_near({tag, " x"}, x_out, ex);
    check_near({tag, " y"}, y_out, ey);
    @(negedge clk);
    check_eq({tag, " R3 done one cycle"}, done, 0);
  endtask

  task automatic test_reset();
    check_eq("R1 busy", busy, 0);
    check_eq("R1 done", done, 0);
    check_eq("R1 x_out", x_out, 0);
    check_eq("R1 y_out", y_out, 0);
  endtask

  task automatic test_sincos(real deg);
    real t;
    t = code_rad(ang_code(deg));
    run_and_check("R2 sincos", 2'b00, 0.0, 0.0, deg, $cos(t), $sin(t));
  endtask

  task automatic test_fold_sincos(real deg);
    real t;
    t = code_rad(ang_code(deg));
    run_and_check("R4 fold sincos", 2'b00, 0.0, 0.0, deg, $cos(t), $sin(t));
  endtask

  task automatic test_rotate(logic [1:0] m, string tag, real xv, real yv, real deg);
    real t;
    t = code_rad(ang_code(deg));
    run_and_check(tag, m, xv, yv, deg,
                  GAIN * (xv * $cos(t) - yv * $sin(t)),
                  GAIN * (xv * $sin(t) + yv * $cos(t)));
  endtask

  task automatic test_polar(real mag, real deg);
    real t;
    t = code_rad(ang_code(deg));
    run_and_check("R6 polar", 2'b10, mag, 0.0, deg, mag * $cos(t), mag * $sin(t));
  endtask

  task automatic test_busy_start();
    real t;
    int extra = 0;
    t = code_rad(ang_code(20.0));
    launch(2'b00, '0, '0, ang_code(20.0));
    repeat (9) @(negedge clk);
    z_in = ang_code(-70.0); mode = 2'b01; x_in = q30(0.3); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    begin
      int cyc = 11;
      while (!done && cyc < 200) begin
        @(negedge clk);
        cyc++;
      end
      check_eq("R7 latency unchanged", cyc, ITER + 1);
    end
    check_near("R7 x kept", x_out, $cos(t));
    check_near("R7 y kept", y_out, $sin(t));
    repeat (40) begin
      @(negedge clk);
      if (done) extra++;
    end
    check_eq("R7 no second done", extra, 0);
  endtask

  task automatic test_hold();
    logic signed [31:0] hx, hy;
    hx = x_out; hy = y_out;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      x_in = 32'(k * 12345); y_in = -32'(k * 777); z_in = 32'(k * 99991); mode = 2'(k);
    end
    check_eq("R8 x held", x_out, hx);
    check_eq("R8 y held", y_out, hy);
    check_eq("R8 still idle", busy, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles_total++;
      if (cycles_total > 100000 && !finished) begin
        finished = 1;
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected<=100000", cycles_total);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 3 + 2);
    test_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_sincos(30.0);
    test_sincos(-45.0);
    test_sincos(0.0);
    test_sincos(89.0);
    test_fold_sincos(135.0);
    test_fold_sincos(-120.0);
    test_fold_sincos(180.0);
    test_fold_sincos(-180.0);
    test_rotate(2'b01, "R5 rotate", 0.5, 0.25, 60.0);
    test_rotate(2'b01, "R5 R4 rotate folded", -0.4, 0.6, 150.0);
    test_rotate(2'b11, "R9 mode11 rotate", 0.5, 0.25, 60.0);
    test_rotate(2'b11, "R9 mode11 folded", 0.3, -0.7, -170.0);
    test_polar(0.9, -100.0);
    test_polar(1.5, 40.0);
    test_busy_start();
    test_hold();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule